// File: doc/BRIEF.md
# Keyed Nonvolatile Write Controller

This block guards and sequences erase and program operations on a nonvolatile array. Software reaches it through four word registers on a simple write port with a combinational read path. The registers are a 16-bit control word, a key register that reads back as zero, and an upper and a lower address register that together form a 24-bit target. An operation can only begin when a start request lands in a single open cycle. That cycle is opened by writing the first key value and then the second key value to the key register. A request that is malformed, misaligned or out of sequence sets a sticky error flag and starts nothing.

Once an operation starts, the controller latches the operation code and the target and pulses a start strobe toward the array. It then holds a busy/stall output high for a cycle count fixed per operation type, and pulses done when that count ends. An asynchronous active-low reset aborts a running operation at once.

Register offsets on `bus_addr`: 0 control, 1 key, 2 upper address, 3 lower address. Control word: bit 15 start (reads 1 while an operation runs), bit 14 write enable, bit 13 sequence error, bits 3:0 operation code. All other bits read 0.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset, the control register reads 0x0000 and busy, done and arr_start are all 0.
- R2: An operation starts only if its control write (bit 15 set) comes in the bus cycle directly after a key write of 0xAA, and that 0xAA write came after a key write of 0x55 with no other bus write in between. An idle cycle after the 0xAA write closes the window, and a start attempt made after that sets the error bit.
- R3: A key write of any value other than the expected one, or a write to any other register between 0x55 and 0xAA, cancels the sequence. A start attempt that follows sets the error bit and starts nothing.
- R4: A start attempt whose written bit 14 (write enable) is 0 sets the error bit and starts nothing.
- R5: Only operation codes 0x0 (configuration byte), 0x1 (double word), 0x2 (row), 0x3 (page erase), 0xA (auxiliary bulk erase) and 0xD (primary bulk erase) can start. Any other code sets the error bit on a start attempt.
- R6: Alignment rules with the default parameters: a double word needs target bits 1:0 = 0, a row needs bits 6:0 = 0, and a page needs bits 9:0 = 0. Configuration and bulk operations have no alignment rule. A misaligned start attempt sets the error bit.
- R7: Busy stays high for exactly the operation's cycle count (defaults: configuration 4, double word 6, row 10, page 12, bulk 16). Done is high for the single cycle after busy falls. Control bit 15 reads 1 while busy and 0 afterwards.
- R8: A successful start clears the error bit. Otherwise the error bit is sticky: a control write without bit 15 keeps it only if the written bit 13 is 1, and a 0 clears it.
- R9: arr_start is a one-cycle pulse in the first busy cycle. arr_op and arr_addr carry the started code and the target {upper[7:0], lower[15:0]}, and they hold steady while busy.
- R10: While busy, writes to the control and address registers are ignored.
- R11: An asynchronous reset during an operation drops busy at once, without waiting for a clock.
- R12: The key register reads 0x0000, and bits 15:8 of the upper address register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 key, 2 upper, 3 lower |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| busy | output | 1 | Operation running; stalls the requester |
| done | output | 1 | One-cycle pulse after an operation ends |
| arr_start | output | 1 | One-cycle strobe to the array at operation start |
| arr_op | output | 4 | Latched operation code |
| arr_addr | output | 24 | Latched 24-bit target |

## Verification
A table walks every implemented code, each with an aligned target and with a target off by less than the code's granule, and also two unimplemented codes and a request with write enable clear. This tells apart a timer or decoder that mixes up durations, and an alignment mask of the wrong width. Directed key sequences cover an idle gap after the second key, a wrong second value, and a foreign register write between the keys. These separate a sequencer that holds its window too long from one that ignores intervening writes. Further directed cases cover writes during busy, reset mid-operation, and the sticky error path, which show whether state leaks through the busy guard.

// File: rtl/nvm_wc_pkg.sv
package nvm_wc_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_KEY   = 2'd1;
  localparam logic [1:0] REG_UPPER = 2'd2;
  localparam logic [1:0] REG_LOWER = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int BIT_START = 15;
  localparam int BIT_WEN   = 14;
  localparam int BIT_ERR   = 13;

  localparam logic [3:0] OP_CFG     = 4'h0;
  localparam logic [3:0] OP_DWORD   = 4'h1;
  localparam logic [3:0] OP_ROW     = 4'h2;
  localparam logic [3:0] OP_PAGE    = 4'h3;
  localparam logic [3:0] OP_AUXBULK = 4'hA;
  localparam logic [3:0] OP_PRIBULK = 4'hD;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ARMED = 2'd1,
    KS_OPEN  = 2'd2
  } key_state_e;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_wc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_wr,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       win_open
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_IDLE: begin
        if (key_wr && key_val == KEY_FIRST) state_d = KS_ARMED;
      end
      KS_ARMED: begin
        if (any_wr) begin
          if (key_wr && key_val == KEY_SECOND) state_d = KS_OPEN;
          else                                 state_d = KS_IDLE;
        end
      end
      KS_OPEN: begin
        if (key_wr && key_val == KEY_FIRST) state_d = KS_ARMED;
        else                                state_d = KS_IDLE;
      end
      default: state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign win_open = (state_q == KS_OPEN);

endmodule

// File: rtl/nvm_op_check.sv
module nvm_op_check
  import nvm_wc_pkg::*;
#(
  parameter int ROW_WORDS  = 64,
  parameter int PAGE_WORDS = 512,
  parameter int CNT_W      = 16,
  parameter int T_CFG      = 4,
  parameter int T_DWORD    = 6,
  parameter int T_ROW      = 10,
  parameter int T_PAGE     = 12,
  parameter int T_BULK     = 16
)(
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] target,
  output logic              op_ok,
  output logic [CNT_W-1:0]  dur
);

  localparam int ROW_LSB  = $clog2(ROW_WORDS) + 1;
  localparam int PAGE_LSB = $clog2(PAGE_WORDS) + 1;
  localparam logic [ADDR_W-1:0] DW_MASK   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ROW_MASK  = (ADDR_W'(1) << ROW_LSB) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1);

  logic legal, aligned;

  always_comb begin
    legal   = 1'b1;
    aligned = 1'b1;
    dur     = CNT_W'(T_BULK);
    unique case (op)
      OP_CFG:   dur = CNT_W'(T_CFG);
      OP_DWORD: begin
        dur     = CNT_W'(T_DWORD);
        aligned = (target & DW_MASK) == '0;
      end
      OP_ROW: begin
        dur     = CNT_W'(T_ROW);
        aligned = (target & ROW_MASK) == '0;
      end
      OP_PAGE: begin
        dur     = CNT_W'(T_PAGE);
        aligned = (target & PAGE_MASK) == '0;
      end
      OP_AUXBULK, OP_PRIBULK: dur = CNT_W'(T_BULK);
      default: legal = 1'b0;
    endcase
  end

  assign op_ok = legal && aligned;

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  output logic             busy,
  output logic             done
);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = dur - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_wc_pkg::*;
#(
  parameter int ROW_WORDS  = 64,
  parameter int PAGE_WORDS = 512,
  parameter int CNT_W      = 16,
  parameter int T_CFG      = 4,
  parameter int T_DWORD    = 6,
  parameter int T_ROW      = 10,
  parameter int T_PAGE     = 12,
  parameter int T_BULK     = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        busy,
  output logic        done,
  output logic        arr_start,
  output logic [3:0]  arr_op,
  output logic [23:0] arr_addr
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic              wen_q, wen_d;
  logic              err_q, err_d;
  logic [3:0]        op_q, op_d;
  logic [7:0]        upper_q, upper_d;
  logic [15:0]       lower_q, lower_d;
  logic [3:0]        aop_q, aop_d;
  logic [ADDR_W-1:0] aaddr_q, aaddr_d;
  logic              astart_q;
  logic              start_go;
  logic              win_open, op_ok;
  logic [CNT_W-1:0]  dur;

  logic ctrl_wr, key_wr, upper_wr, lower_wr;
  assign ctrl_wr  = bus_wr && bus_addr == REG_CTRL;
  assign key_wr   = bus_wr && bus_addr == REG_KEY;
  assign upper_wr = bus_wr && bus_addr == REG_UPPER;
  assign lower_wr = bus_wr && bus_addr == REG_LOWER;

  nvm_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .any_wr   (bus_wr),
    .key_wr   (key_wr),
    .key_val  (bus_wdata[7:0]),
    .win_open (win_open)
  );

  nvm_op_check #(
    .ROW_WORDS (ROW_WORDS), .PAGE_WORDS (PAGE_WORDS), .CNT_W (CNT_W),
    .T_CFG (T_CFG), .T_DWORD (T_DWORD), .T_ROW (T_ROW),
    .T_PAGE (T_PAGE), .T_BULK (T_BULK)
  ) u_chk_op (
    .op     (bus_wdata[3:0]),
    .target ({upper_q, lower_q}),
    .op_ok  (op_ok),
    .dur    (dur)
  );

  nvm_op_timer #(.CNT_W (CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (start_go),
    .dur   (dur),
    .busy  (busy),
    .done  (done)
  );

  always_comb begin
    wen_d    = wen_q;
    err_d    = err_q;
    op_d     = op_q;
    upper_d  = upper_q;
    lower_d  = lower_q;
    aop_d    = aop_q;
    aaddr_d  = aaddr_q;
    start_go = 1'b0;
    if (!busy) begin
      if (ctrl_wr) begin
        wen_d = bus_wdata[BIT_WEN];
        op_d  = bus_wdata[3:0];
        if (bus_wdata[BIT_START]) begin
          if (win_open && bus_wdata[BIT_WEN] && op_ok) begin
            start_go = 1'b1;
            err_d    = 1'b0;
            aop_d    = bus_wdata[3:0];
            aaddr_d  = {upper_q, lower_q};
          end else begin
            err_d = 1'b1;
          end
        end else begin
          err_d = err_q & bus_wdata[BIT_ERR];
        end
      end
      if (upper_wr) upper_d = bus_wdata[7:0];
      if (lower_wr) lower_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wen_q    <= 1'b0;
      err_q    <= 1'b0;
      op_q     <= '0;
      upper_q  <= '0;
      lower_q  <= '0;
      aop_q    <= '0;
      aaddr_q  <= '0;
      astart_q <= 1'b0;
    end else begin
      wen_q    <= wen_d;
      err_q    <= err_d;
      op_q     <= op_d;
      upper_q  <= upper_d;
      lower_q  <= lower_d;
      aop_q    <= aop_d;
      aaddr_q  <= aaddr_d;
      astart_q <= start_go;
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_CTRL:  bus_rdata = {busy, wen_q, err_q, 9'b0, op_q};
      REG_UPPER: bus_rdata = {8'b0, upper_q};
      REG_LOWER: bus_rdata = lower_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign arr_start = astart_q;
  assign arr_op    = aop_q;
  assign arr_addr  = aaddr_q;

endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic        busy,
  input logic        done,
  input logic        arr_start,
  input logic [3:0]  arr_op,
  input logic [23:0] arr_addr,
  input logic        win_open
);

  // R2
  window_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> !win_open);

  // R2
  start_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(win_open && bus_wr && bus_addr == 2'd0));

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arr_start);

  // R9
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arr_start) |-> ($stable(arr_addr) && $stable(arr_op)));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_start && arr_op == 4'h1) |-> (arr_addr[1:0] == 2'b00));

endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk u_nvm_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .busy      (busy),
  .done      (done),
  .arr_start (arr_start),
  .arr_op    (arr_op),
  .arr_addr  (arr_addr),
  .win_open  (win_open)
);

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        busy, done, arr_start;
  logic [3:0]  arr_op;
  logic [23:0] arr_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nvm_write_ctrl i_nvm_write_ctrl (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .busy (busy),
    .done (done), .arr_start (arr_start), .arr_op (arr_op), .arr_addr (arr_addr)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [23:0] addr;
    logic        wen;
    logic        ok;
    logic [7:0]  dur;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 24'h123457, 1'b1, 1'b1, 8'd4},   // R5 cfg, no alignment
    '{4'h1, 24'h022004, 1'b1, 1'b1, 8'd6},   // R6 dword aligned
    '{4'h1, 24'h022002, 1'b1, 1'b0, 8'd0},   // R6 dword misaligned
    '{4'h2, 24'h022080, 1'b1, 1'b1, 8'd10},  // R6 row aligned
    '{4'h2, 24'h022040, 1'b1, 1'b0, 8'd0},   // R6 row misaligned
    '{4'h3, 24'h022400, 1'b1, 1'b1, 8'd12},  // R6 page aligned
    '{4'h3, 24'h022200, 1'b1, 1'b0, 8'd0},   // R6 page misaligned
    '{4'hA, 24'h000013, 1'b1, 1'b1, 8'd16},  // R5 aux bulk
    '{4'hD, 24'hFFFFFF, 1'b1, 1'b1, 8'd16},  // R5 primary bulk
    '{4'h4, 24'h000000, 1'b1, 1'b0, 8'd0},   // R5 unimplemented
    '{4'hF, 24'h000000, 1'b1, 1'b0, 8'd0},   // R5 unimplemented
    '{4'h1, 24'h000008, 1'b0, 1'b0, 8'd0},   // R4 write enable clear
    '{4'h2, 24'hAB0000, 1'b1, 1'b1, 8'd10}   // R9 upper byte reaches target
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; write is taken at the next posedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic unlock_start(input logic [3:0] op, input logic wen);
    wr(2'd1, 16'h0055);
    wr(2'd1, 16'h00AA);
    wr(2'd0, {1'b1, wen, 1'b0, 9'b0, op});
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int n;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, r);
    chk("R1 ctrl", r, 16'h0000);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 arr_start", arr_start, 1'b0);

    // vector walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, {8'h00, VECS[i].addr[23:16]});
      wr(2'd3, VECS[i].addr[15:0]);
      unlock_start(VECS[i].op, VECS[i].wen);
      if (VECS[i].ok) begin
        chk($sformatf("R9 arr_start v%0d", i), arr_start, 1'b1);
        chk($sformatf("R9 arr_op v%0d", i), arr_op, VECS[i].op);
        chk($sformatf("R9 arr_addr v%0d", i), arr_addr, VECS[i].addr);
        wait_idle(n);
        chk($sformatf("R7 busy length v%0d", i), n, VECS[i].dur);
        chk($sformatf("R7 done v%0d", i), done, 1'b1);
        rd(2'd0, r);
        chk($sformatf("R8 ctrl after op v%0d", i), r, {1'b0, 1'b1, 1'b0, 9'b0, VECS[i].op});
      end else begin
        chk($sformatf("R5 no busy v%0d", i), busy, 1'b0);
        chk($sformatf("R4 no arr_start v%0d", i), arr_start, 1'b0);
        rd(2'd0, r);
        chk($sformatf("R6 error v%0d", i), r[15:13], {1'b0, VECS[i].wen, 1'b1});
        wr(2'd0, 16'h0000);
      end
    end

    // R2 idle gap closes the window
    wr(2'd2, 16'h0000); wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA);
    @(negedge clk);
    wr(2'd0, 16'hC001);
    chk("R2 gap no busy", busy, 1'b0);
    rd(2'd0, r);
    chk("R2 gap error", r[13], 1'b1);
    wr(2'd0, 16'h0000);

    // R3 wrong second value
    wr(2'd1, 16'h0055); wr(2'd1, 16'h00AB); wr(2'd1, 16'h00AA);
    wr(2'd0, 16'hC001);
    chk("R3 wrong key no busy", busy, 1'b0);
    rd(2'd0, r);
    chk("R3 wrong key error", r[13], 1'b1);
    wr(2'd0, 16'h0000);

    // R3 foreign write between keys
    wr(2'd1, 16'h0055); wr(2'd2, 16'h0000); wr(2'd1, 16'h00AA);
    wr(2'd0, 16'hC001);
    chk("R3 intervening write no busy", busy, 1'b0);
    rd(2'd0, r);
    chk("R3 intervening write error", r[13], 1'b1);

    // R8 sticky error, then cleared by a good start; R7 start bit reads 1 while busy
    wr(2'd0, 16'h6001);
    rd(2'd0, r);
    chk("R8 error kept", r, 16'h6001);
    unlock_start(4'h1, 1'b1);
    rd(2'd0, r);
    chk("R7 ctrl while busy", r, 16'hC001);
    wait_idle(n);

    // R10 writes ignored while busy
    wr(2'd2, 16'h0002); wr(2'd3, 16'h2400);
    unlock_start(4'h3, 1'b1);
    wr(2'd3, 16'h1111);
    wr(2'd2, 16'h0077);
    wr(2'd0, 16'h0002);
    wait_idle(n);
    rd(2'd3, r);
    chk("R10 lower unchanged", r, 16'h2400);
    rd(2'd2, r);
    chk("R10 upper unchanged", r, 16'h0002);
    rd(2'd0, r);
    chk("R10 ctrl unchanged", r, 16'h4003);

    // R12 key reads zero, upper high byte reads zero
    wr(2'd1, 16'h0055);
    rd(2'd1, r);
    chk("R12 key read", r, 16'h0000);
    wr(2'd2, 16'hFF12);
    rd(2'd2, r);
    chk("R12 upper read", r, 16'h0012);

    // R11 reset aborts a running operation
    unlock_start(4'hA, 1'b1);
    repeat (3) @(negedge clk);
    chk("R11 busy before reset", busy, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R11 busy dropped", busy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, r);
    chk("R11 R1 ctrl after reset", r, 16'h0000);
    chk("R11 done after reset", done, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule